// File: doc/BRIEF.md
# Tensor Opcode Fan-In Selector

This block takes one generic tensor-tensor request and chooses the concrete instruction byte that will carry it, together with the execution-engine code that travels beside that byte. The request describes the two source element types, the destination element type, the ALU operation, a scan flag, a wide-result flag, a per-operand flag saying whether that operand sits in the partial-sum buffer, an engine hint from the caller (which may be "unknown"), and a generation target.

The choice is a prioritized match. Scan wins over everything. Next come bitwise operations, then the packed-BF16 forms that only the oldest generation has, then the wide-integer form that only the newest generation has, and finally the generic opcode. The engine is resolved separately from the opcode and never changes the byte. A request that no form can serve raises an error flag and carries the invalid opcode. Results leave through a single register stage with a valid/ready handshake, so a request's result appears one cycle after it is accepted.

Codes used throughout: element types fp32=0, bf16=1, int32=2, uint32=3, int16=4, uint16=5, int8=6, uint8=7. ALU ops add=0x00, subtract=0x01, multiply=0x02, power=0x03, max=0x04, and any op whose upper nibble is 0x1 is a bitwise/logical op. Generations are 0 (oldest) to 3 (newest). Engines unknown=0, tensor=1, scalar=2, gpsimd=3, dma=4, vector=5, sync=6. The partial-sum flags are one bus: bit 0 source 0, bit 1 source 1, bit 2 destination.

Top module: `tt_route_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request with `req_scan` set yields opcode 0xE5 with no error, on every generation and for every type and op.
- R3: Without scan, a bitwise op (upper nibble 0x1) yields opcode 0x51 and engine 5 (vector) whatever the hint.
- R4: Without scan or bitwise op, when both sources are bf16 and the generation is 0, add gives 0x8A, multiply 0x8B and subtract 0x8F; on generations 1 to 3 the same request gives 0x41.
- R5: Otherwise, when `req_wide` is set and both source types are integer (codes 2 to 7), generation 3 gives opcode 0xF3 with no error.
- R6: The same wide integer request on generations 0 to 2 raises `rsp_err`, with opcode 0xFF and engine 0.
- R7: Every request not covered by R2 to R6 yields opcode 0x41 with no error; `req_wide` with a non-integer source is ignored.
- R8: With hint 0, an op in {add, subtract, multiply}, all three types int32 or uint32 and every partial-sum flag clear, the engine is 3 (gpsimd); any other hint-0 case gives 5 (vector).
- R9: A power op always gives engine 3; otherwise a nonzero hint is passed to the engine output unchanged.
- R10: An accepted request (`req_valid` and `req_ready`) produces `rsp_valid` on the next cycle; while `rsp_valid` is 1 and `rsp_ready` is 0 the response holds steady and `req_ready` is 0.
- R11: The opcode does not depend on the engine hint or the partial-sum flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_src0_type | input | 3 | Element type of source 0 |
| req_src1_type | input | 3 | Element type of source 1 |
| req_dst_type | input | 3 | Element type of the destination |
| req_alu_op | input | 8 | ALU operation code |
| req_scan | input | 1 | Scan form requested |
| req_wide | input | 1 | Wide (low and high half) result requested |
| req_psum | input | 3 | Partial-sum buffer flags: src0, src1, dst |
| req_eng_hint | input | 3 | Caller engine choice, 0 = unknown |
| req_gen | input | 2 | Generation target, 0 oldest, 3 newest |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_opcode | output | 8 | Selected instruction byte |
| rsp_engine | output | 3 | Selected engine code |
| rsp_err | output | 1 | No form fits the request |

## Verification
A wrong priority or a mistaken generation test inside the selector shows up as a wrong opcode byte on the very next response, one cycle after the request is accepted, because there is no state between the match and the output register other than that register itself. A wrong engine rule shows up the same way on `rsp_engine`, and because the engine is resolved apart from the opcode, such a fault leaves the opcode intact, which is why the sweeps compare both fields separately. A broken handshake register shows as a response that changes or vanishes while `rsp_ready` is low, or as a missing `rsp_valid` the cycle after a fire.

// File: rtl/tt_sel_pkg.sv
package tt_sel_pkg;

  localparam int DT_W  = 3;
  localparam int OP_W  = 8;
  localparam int ENG_W = 3;
  localparam int GEN_W = 2;
  localparam int PS_W  = 3;
  localparam int RSP_W = 1 + ENG_W + 8;
  localparam logic [GEN_W-1:0] GEN_OLDEST = '0;
  localparam logic [GEN_W-1:0] GEN_NEWEST = '1;

  localparam logic [DT_W-1:0] DT_FP32   = 3'd0;
  localparam logic [DT_W-1:0] DT_BF16   = 3'd1;
  localparam logic [DT_W-1:0] DT_INT32  = 3'd2;
  localparam logic [DT_W-1:0] DT_UINT32 = 3'd3;

  localparam logic [OP_W-1:0] OP_ADD = 8'h00;
  localparam logic [OP_W-1:0] OP_SUB = 8'h01;
  localparam logic [OP_W-1:0] OP_MUL = 8'h02;
  localparam logic [OP_W-1:0] OP_POW = 8'h03;

  localparam logic [7:0] OPC_GENERIC = 8'h41;
  localparam logic [7:0] OPC_BITVEC  = 8'h51;
  localparam logic [7:0] OPC_BF_ADD  = 8'h8A;
  localparam logic [7:0] OPC_BF_MUL  = 8'h8B;
  localparam logic [7:0] OPC_BF_SUB  = 8'h8F;
  localparam logic [7:0] OPC_SCAN    = 8'hE5;
  localparam logic [7:0] OPC_WIDE    = 8'hF3;
  localparam logic [7:0] OPC_INVALID = 8'hFF;

  typedef enum logic [ENG_W-1:0] {
    ENG_UNKNOWN = 3'd0,
    ENG_TENSOR  = 3'd1,
    ENG_SCALAR  = 3'd2,
    ENG_GPSIMD  = 3'd3,
    ENG_DMA     = 3'd4,
    ENG_VECTOR  = 3'd5,
    ENG_SYNC    = 3'd6
  } eng_e;

  typedef enum logic [2:0] {
    RT_SCAN, RT_BITVEC, RT_BF16, RT_WIDE, RT_WIDE_BAD, RT_GENERIC
  } route_e;

  function automatic logic is_int_dt(input logic [DT_W-1:0] t);
    return t >= 3'd2;
  endfunction

  function automatic logic is_word_int(input logic [DT_W-1:0] t);
    return (t == DT_INT32) || (t == DT_UINT32);
  endfunction

  function automatic logic is_bitvec_op(input logic [OP_W-1:0] op);
    return op[OP_W-1:4] == 4'h1;
  endfunction

  function automatic logic is_basic_arith(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

  function automatic logic [7:0] bf16_code(input logic [OP_W-1:0] op);
    case (op)
      OP_ADD:  return OPC_BF_ADD;
      OP_MUL:  return OPC_BF_MUL;
      default: return OPC_BF_SUB;
    endcase
  endfunction

endpackage

// File: rtl/tt_engine_resolve.sv
module tt_engine_resolve
  import tt_sel_pkg::*;
(
  input  logic [DT_W-1:0]  src0_type,
  input  logic [DT_W-1:0]  src1_type,
  input  logic [DT_W-1:0]  dst_type,
  input  logic [OP_W-1:0]  alu_op,
  input  logic [PS_W-1:0]  psum,
  input  logic [ENG_W-1:0] hint,
  output logic [ENG_W-1:0] eng,
  output logic             auto_gp
);

  logic all_word_int;
  assign all_word_int = is_word_int(src0_type) && is_word_int(src1_type)
                     && is_word_int(dst_type);

  assign auto_gp = (hint == ENG_UNKNOWN) && is_basic_arith(alu_op)
                && all_word_int && (psum == '0);

  always_comb begin
    if (alu_op == OP_POW)           eng = ENG_GPSIMD;
    else if (hint != ENG_UNKNOWN)   eng = hint;
    else if (auto_gp)               eng = ENG_GPSIMD;
    else                            eng = ENG_VECTOR;
  end

endmodule

// File: rtl/tt_opcode_match.sv
module tt_opcode_match
  import tt_sel_pkg::*;
(
  input  logic [DT_W-1:0]  src0_type,
  input  logic [DT_W-1:0]  src1_type,
  input  logic [OP_W-1:0]  alu_op,
  input  logic             scan,
  input  logic             wide,
  input  logic [GEN_W-1:0] gen,
  output route_e           route,
  output logic [7:0]       opcode
);

  logic bf16_pair, bf16_form, int_pair;
  assign bf16_pair = (src0_type == DT_BF16) && (src1_type == DT_BF16);
  assign bf16_form = bf16_pair && (gen == GEN_OLDEST) && is_basic_arith(alu_op);
  assign int_pair  = is_int_dt(src0_type) && is_int_dt(src1_type);

  always_comb begin
    if (scan)                      route = RT_SCAN;
    else if (is_bitvec_op(alu_op)) route = RT_BITVEC;
    else if (bf16_form)            route = RT_BF16;
    else if (wide && int_pair)     route = (gen == GEN_NEWEST) ? RT_WIDE : RT_WIDE_BAD;
    else                           route = RT_GENERIC;
  end

  always_comb begin
    case (route)
      RT_SCAN:     opcode = OPC_SCAN;
      RT_BITVEC:   opcode = OPC_BITVEC;
      RT_BF16:     opcode = bf16_code(alu_op);
      RT_WIDE:     opcode = OPC_WIDE;
      RT_WIDE_BAD: opcode = OPC_INVALID;
      default:     opcode = OPC_GENERIC;
    endcase
  end

endmodule

// File: rtl/tt_rsp_stage.sv
module tt_rsp_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic fire;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_fire_gives_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  p_stall_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/tt_route_sel.sv
module tt_route_sel
  import tt_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_src0_type,
  input  logic [2:0]       req_src1_type,
  input  logic [2:0]       req_dst_type,
  input  logic [7:0]       req_alu_op,
  input  logic             req_scan,
  input  logic             req_wide,
  input  logic [2:0]       req_psum,
  input  logic [2:0]       req_eng_hint,
  input  logic [1:0]       req_gen,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_opcode,
  output logic [2:0]       rsp_engine,
  output logic             rsp_err
);

  route_e            route;
  logic [7:0]        sel_opcode;
  logic [ENG_W-1:0]  resolved_eng;
  logic [ENG_W-1:0]  sel_eng;
  logic              auto_gp;
  logic              sel_err;
  logic              req_fire;
  logic [RSP_W-1:0]  rsp_word;

  tt_opcode_match u_match (
    .src0_type (req_src0_type),
    .src1_type (req_src1_type),
    .alu_op    (req_alu_op),
    .scan      (req_scan),
    .wide      (req_wide),
    .gen       (req_gen),
    .route     (route),
    .opcode    (sel_opcode)
  );

  tt_engine_resolve u_eng (
    .src0_type (req_src0_type),
    .src1_type (req_src1_type),
    .dst_type  (req_dst_type),
    .alu_op    (req_alu_op),
    .psum      (req_psum),
    .hint      (req_eng_hint),
    .eng       (resolved_eng),
    .auto_gp   (auto_gp)
  );

  // Engine field is merged here; the opcode path never sees it.
  assign sel_err = (route == RT_WIDE_BAD);
  always_comb begin
    if (sel_err)                  sel_eng = ENG_UNKNOWN;
    else if (route == RT_BITVEC)  sel_eng = ENG_VECTOR;
    else                          sel_eng = resolved_eng;
  end

  tt_rsp_stage #(.W(RSP_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   ({sel_err, sel_eng, sel_opcode}),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_word)
  );

  assign rsp_err    = rsp_word[RSP_W-1];
  assign rsp_engine = rsp_word[RSP_W-2 -: ENG_W];
  assign rsp_opcode = rsp_word[7:0];
  assign req_fire   = req_valid && req_ready;

  p_scan_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_scan) |=> (rsp_opcode == OPC_SCAN && !rsp_err));

  p_bitvec_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_scan && is_bitvec_op(req_alu_op))
      |=> (rsp_opcode == OPC_BITVEC && rsp_engine == ENG_VECTOR));

  p_wide_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && route == RT_WIDE) |=> (rsp_opcode == OPC_WIDE && !rsp_err));

  p_err_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_opcode == OPC_INVALID && rsp_engine == ENG_UNKNOWN));

  p_auto_gpsimd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && route == RT_GENERIC && auto_gp) |=> (rsp_engine == ENG_GPSIMD));

  p_power_gpsimd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_alu_op == OP_POW && route != RT_WIDE_BAD)
      |=> (rsp_engine == ENG_GPSIMD));

  p_hint_passes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && route == RT_GENERIC && req_alu_op != OP_POW && req_eng_hint != ENG_UNKNOWN)
      |=> (rsp_engine == $past(req_eng_hint)));

endmodule

// File: tb/tt_route_sel_bench.sv
module tt_route_sel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_src0_type = '0;
  logic [2:0] req_src1_type = '0;
  logic [2:0] req_dst_type = '0;
  logic [7:0] req_alu_op = '0;
  logic       req_scan = 1'b0;
  logic       req_wide = 1'b0;
  logic [2:0] req_psum = '0;
  logic [2:0] req_eng_hint = '0;
  logic [1:0] req_gen = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_opcode;
  logic [2:0] rsp_engine;
  logic       rsp_err;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tt_route_sel u_tt_route_sel (.*);

  // Expected {err, engine, opcode}, derived from the requirement text.
  function automatic logic [11:0] model(input logic [2:0] a, b, d, input logic [7:0] op,
      input logic sc, wd, input logic [2:0] ps, input logic [2:0] hint, input logic [1:0] g);
    logic [2:0] e;
    logic word3;
    word3 = (a == 2 || a == 3) && (b == 2 || b == 3) && (d == 2 || d == 3);
    if (op == 8'h03)                                  e = 3'd3;
    else if (hint != 0)                               e = hint;
    else if (op <= 8'h02 && word3 && ps == 3'b000)    e = 3'd3;
    else                                              e = 3'd5;
    if (sc)                                           return {1'b0, e, 8'hE5};
    if (op >= 8'h10 && op <= 8'h1F)                   return {1'b0, 3'd5, 8'h51};
    if (g == 0 && a == 1 && b == 1 && op <= 8'h02)
      return {1'b0, e, (op == 8'h00) ? 8'h8A : (op == 8'h02) ? 8'h8B : 8'h8F};
    if (wd && a >= 2 && b >= 2)
      return (g == 2'd3) ? {1'b0, e, 8'hF3} : {1'b1, 3'd0, 8'hFF};
    return {1'b0, e, 8'h41};
  endfunction

  function automatic string tag_of(input logic [2:0] a, b, input logic [7:0] op,
      input logic sc, wd, input logic [2:0] hint, input logic [1:0] g);
    if (sc) return "R2";
    if (op[7:4] == 4'h1) return "R3";
    if (a == 1 && b == 1 && op <= 8'h02) return "R4";
    if (wd && a >= 2 && b >= 2) return (g == 2'd3) ? "R5" : "R6";
    if (op == 8'h03 || hint != 0) return "R9";
    return (op <= 8'h02) ? "R8" : "R7";
  endfunction

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got err=%0b eng=%0d opc=%02h, expected err=%0b eng=%0d opc=%02h",
               tag, got[11], got[10:8], got[7:0], exp[11], exp[10:8], exp[7:0]);
    end
  endtask

  task automatic drive(input logic [2:0] a, b, d, input logic [7:0] op, input logic sc, wd,
      input logic [2:0] ps, input logic [2:0] hint, input logic [1:0] g);
    req_src0_type = a; req_src1_type = b; req_dst_type = d; req_alu_op = op;
    req_scan = sc; req_wide = wd; req_psum = ps; req_eng_hint = hint; req_gen = g;
  endtask

  // One request per cycle: drive, accept at the edge, check 2 ns later.
  task automatic apply(input logic [2:0] a, b, d, input logic [7:0] op, input logic sc, wd,
      input logic [2:0] ps, input logic [2:0] hint, input logic [1:0] g, input string tag);
    drive(a, b, d, op, sc, wd, ps, hint, g);
    req_valid = 1'b1;
    @(posedge clk); #2;
    check(tag, {rsp_err, rsp_engine, rsp_opcode}, model(a, b, d, op, sc, wd, ps, hint, g));
    if (rsp_valid !== 1'b1) check("R10", 12'd0, 12'd1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] dts [4];
    logic [7:0] ops [6];
    logic [2:0] pss [4];
    logic [2:0] hts [3];
    logic [2:0] extra [4];
    logic [7:0] base_opc;
    dts = '{3'd0, 3'd1, 3'd2, 3'd3};
    ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h13};
    pss = '{3'b000, 3'b001, 3'b010, 3'b100};
    hts = '{3'd0, 3'd5, 3'd3};
    extra = '{3'd4, 3'd5, 3'd6, 3'd7};

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1", {10'd0, rsp_valid, req_ready}, {10'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", {10'd0, rsp_valid, req_ready}, {10'd0, 1'b0, 1'b1});

    // Main sweep over types, ops, flags, partial-sum patterns, hints and generations.
    for (int ia = 0; ia < 4; ia++)
      for (int ib = 0; ib < 4; ib++)
        for (int id = 0; id < 4; id++)
          for (int io = 0; io < 6; io++)
            for (int sc = 0; sc < 2; sc++)
              for (int wd = 0; wd < 2; wd++)
                for (int ip = 0; ip < 4; ip++)
                  for (int ih = 0; ih < 3; ih++)
                    for (int g = 0; g < 4; g++)
                      apply(dts[ia], dts[ib], dts[id], ops[io], sc[0], wd[0], pss[ip],
                            hts[ih], g[1:0],
                            tag_of(dts[ia], dts[ib], ops[io], sc[0], wd[0], hts[ih], g[1:0]));

    // R5/R6 with narrow integer sources, and the other explicit hints (R9).
    for (int ie = 0; ie < 4; ie++)
      for (int g = 0; g < 4; g++) begin
        apply(extra[ie], 3'd2, 3'd0, 8'h00, 1'b0, 1'b1, 3'b000, 3'd0, g[1:0],
              (g == 3) ? "R5" : "R6");
        apply(extra[ie], extra[ie], 3'd6, 8'h01, 1'b0, 1'b0, 3'b000, 3'd0, g[1:0], "R7");
      end
    for (int h = 1; h < 7; h++)
      apply(3'd2, 3'd2, 3'd2, 8'h00, 1'b0, 1'b0, 3'b000, h[2:0], 2'd1, "R9");

    // R11: opcode unchanged across every hint and partial-sum pattern.
    for (int g = 0; g < 4; g++) begin
      base_opc = model(3'd1, 3'd1, 3'd0, 8'h02, 1'b0, 1'b0, 3'b000, 3'd0, g[1:0]);
      for (int h = 0; h < 7; h++)
        for (int p = 0; p < 8; p++) begin
          drive(3'd1, 3'd1, 3'd0, 8'h02, 1'b0, 1'b0, p[2:0], h[2:0], g[1:0]);
          req_valid = 1'b1;
          @(posedge clk); #2;
          check("R11", {4'd0, rsp_opcode}, {4'd0, base_opc});
        end
    end

    // R10: stall behaviour.
    req_valid = 1'b0;
    @(posedge clk); #2;
    check("R10", {11'd0, rsp_valid}, 12'd0);
    rsp_ready = 1'b0;
    drive(3'd1, 3'd1, 3'd1, 8'h00, 1'b0, 1'b0, 3'b000, 3'd0, 2'd0);
    req_valid = 1'b1;
    @(posedge clk); #2;
    check("R10", {3'd0, rsp_valid, rsp_opcode}, {3'd0, 1'b1, 8'h8A});
    check("R10", {11'd0, req_ready}, 12'd0);
    drive(3'd0, 3'd0, 3'd0, 8'h00, 1'b1, 1'b0, 3'b000, 3'd0, 2'd2);
    repeat (3) begin
      @(posedge clk); #2;
      check("R10", {3'd0, rsp_valid, rsp_opcode}, {3'd0, 1'b1, 8'h8A});
    end
    rsp_ready = 1'b1;
    #0;
    check("R10", {11'd0, req_ready}, 12'd1);
    @(posedge clk); #2;
    check("R10", {3'd0, rsp_valid, rsp_opcode}, {3'd0, 1'b1, 8'hE5});
    req_valid = 1'b0;
    @(posedge clk); #2;
    check("R10", {11'd0, rsp_valid}, 12'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule